// File: doc/BRIEF.md
# Eight-Bit Stack Processor Core

This block is a small multi-cycle processor with an 8-bit datapath. It reads byte-wide instructions from a 256-byte memory that holds both the program and the stack. It has eight general registers, and the highest-numbered register acts as the stack pointer. The instruction set has six operations: stop, load an immediate value, emit a register value, multiply, push and pop. An unknown opcode stops the core and raises a sticky error.

A program is placed in memory through a byte-wide preload port, normally while reset is held. After reset is released, execution starts at address 0. Each instruction takes one opcode byte and then zero, one or two operand bytes. The first operand names a register. The second operand is either an immediate value or a second register. The emit instruction drives an output strobe for one cycle with the register value on an 8-bit bus. A halted flag shows when the core has stopped.

Top module: `cpu8_core`

## Requirements
- R1: After synchronous reset, `halted`, `illegal` and `out_valid` are 0. Registers 0 to 6 read 0 and register 7 reads 0xF4. The first opcode is fetched from address 0.
- R2: Opcode 0x82 (operands: register index, immediate) writes the immediate byte into the named register.
- R3: Opcode 0x47 (operand: register index) raises `out_valid` for exactly one cycle, with `out_data` equal to the named register.
- R4: Opcode 0xA2 (operands: two register indices) writes the low 8 bits of the product of the two registers into the first register.
- R5: Opcode 0x45 (operand: register index) first decrements register 7, then stores the named register at the memory address given by the new register 7 value.
- R6: Opcode 0x46 (operand: register index) loads the named register from memory at register 7, then increments register 7.
- R7: Register 7 wraps modulo 256: a push at 0x00 stores at 0xFF, and a pop at 0xFF leaves 0x00.
- R8: An instruction is one byte plus as many operand bytes as bits 7:6 of its opcode give. Instructions execute back to back in address order, so emitted values appear in program order.
- R9: Opcode 0x01 sets `halted`. After that, `halted` stays 1, the program counter no longer changes and `out_valid` stays 0 until reset.
- R10: Any opcode other than 0x01, 0x82, 0x47, 0xA2, 0x45 and 0x46 sets both `halted` and `illegal`. Both stay set until reset.
- R11: While `load_en` is 1, the byte `load_data` is written to memory at `load_addr` on each clock edge, and the core does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Preload write strobe; stalls the core while high |
| load_addr | input | 8 | Preload byte address |
| load_data | input | 8 | Preload byte value |
| out_valid | output | 1 | One-cycle strobe from the emit instruction |
| out_data | output | 8 | Register value emitted |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Sticky unknown-opcode flag |

## Verification
The bench builds the core with its default parameters: an 8-bit address, an 8-bit datapath and eight registers. This makes the full 256-byte space reachable. With that space, the stack pointer can be forced to 0x00 and 0xFF to exercise wrap-around in both directions. A byte preloaded at 0xF4 can also be popped straight out of reset. Register contents are observed only through the emit instruction. The preload port is kept active after reset is released, to show that a stalled core picks up operand bytes that were rewritten during the stall.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

  localparam logic [7:0] OP_HALT = 8'h01;
  localparam logic [7:0] OP_LDI  = 8'h82;
  localparam logic [7:0] OP_PRN  = 8'h47;
  localparam logic [7:0] OP_MUL  = 8'hA2;
  localparam logic [7:0] OP_PUSH = 8'h45;
  localparam logic [7:0] OP_POP  = 8'h46;

  typedef enum logic [2:0] {
    K_HALT, K_LDI, K_PRN, K_MUL, K_PUSH, K_POP, K_BAD
  } kind_t;

  typedef enum logic [3:0] {
    S_F0,     // issue opcode read
    S_F1,     // opcode arrives, decode
    S_OPA,    // first operand arrives
    S_OPB,    // second operand arrives
    S_EXEC,   // perform operation
    S_PUSHW,  // store to stack
    S_POPW,   // load from stack
    S_POPI,   // bump stack pointer
    S_STOP    // stopped for good
  } st_t;

endpackage

// File: rtl/cpu8_dec.sv
module cpu8_dec
  import cpu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] op,
  output kind_t         kind,
  output logic [1:0]    nopnd
);

  always_comb begin
    nopnd = op[DW-1 -: 2];
    case (op)
      OP_HALT: kind = K_HALT;
      OP_LDI:  kind = K_LDI;
      OP_PRN:  kind = K_PRN;
      OP_MUL:  kind = K_MUL;
      OP_PUSH: kind = K_PUSH;
      OP_POP:  kind = K_POP;
      default: kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/cpu8_mem.sv
module cpu8_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq
);

  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[wa] <= wd;
    if (re) rq <= ram[ra];
  end

endmodule

// File: rtl/cpu8_regs.sv
module cpu8_regs #(
  parameter int            NREG    = 8,
  parameter int            DW      = 8,
  parameter int            SP_IDX  = NREG - 1,
  parameter logic [DW-1:0] SP_INIT = 8'hF4,
  parameter int            RW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [RW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [RW-1:0] ra_a,
  input  logic [RW-1:0] ra_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  output logic [DW-1:0] sp_o
);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= (i == SP_IDX) ? SP_INIT : '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];
  assign sp_o = regs[SP_IDX];

endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter int            AW      = 8,
  parameter int            DW      = 8,
  parameter int            NREG    = 8,
  parameter int            SP_IDX  = NREG - 1,
  parameter logic [DW-1:0] SP_INIT = 8'hF4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          halted,
  output logic          illegal
);

  localparam int RW = $clog2(NREG);

  st_t           st;
  kind_t         kind_q, kind_d;
  logic [1:0]    len_q, len_d;
  logic [AW-1:0] pc_q;
  logic [RW-1:0] opa_q;
  logic [DW-1:0] opb_q;
  logic [DW-1:0] mem_q;
  logic [DW-1:0] rd_a, rd_b, sp_v, prod;
  logic          go;
  logic          rf_we, core_we, retire;
  logic [RW-1:0] rf_wa;
  logic [DW-1:0] rf_wd;
  logic [AW-1:0] rd_addr;

  assign go   = !load_en;
  assign prod = rd_a * rd_b;

  cpu8_dec #(.DW(DW)) u_dec (
    .op    (mem_q),
    .kind  (kind_d),
    .nopnd (len_d)
  );

  cpu8_regs #(
    .NREG(NREG), .DW(DW), .SP_IDX(SP_IDX), .SP_INIT(SP_INIT), .RW(RW)
  ) u_regs (
    .clk  (clk),
    .rst  (rst),
    .we   (rf_we && go),
    .wa   (rf_wa),
    .wd   (rf_wd),
    .ra_a (opa_q),
    .ra_b (opb_q[RW-1:0]),
    .rd_a (rd_a),
    .rd_b (rd_b),
    .sp_o (sp_v)
  );

  cpu8_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk (clk),
    .we  (load_en || (core_we && go)),
    .wa  (load_en ? load_addr : AW'(sp_v)),
    .wd  (load_en ? load_data : rd_a),
    .re  (go),
    .ra  (rd_addr),
    .rq  (mem_q)
  );

  // Datapath steering for the current step.
  always_comb begin
    rd_addr = pc_q;
    rf_we   = 1'b0;
    rf_wa   = opa_q;
    rf_wd   = opb_q;
    core_we = 1'b0;
    retire  = 1'b0;
    case (st)
      S_F1:  rd_addr = pc_q + AW'(1);
      S_OPA: rd_addr = pc_q + AW'(2);
      S_EXEC: begin
        case (kind_q)
          K_LDI: begin rf_we = 1'b1; retire = 1'b1; end
          K_MUL: begin rf_we = 1'b1; rf_wd = prod; retire = 1'b1; end
          K_PRN: retire = 1'b1;
          K_PUSH: begin
            rf_we = 1'b1;
            rf_wa = RW'(SP_IDX);
            rf_wd = sp_v - DW'(1);
          end
          K_POP:   rd_addr = AW'(sp_v);
          default: ;
        endcase
      end
      S_PUSHW: begin core_we = 1'b1; retire = 1'b1; end
      S_POPW:  begin rf_we = 1'b1; rf_wd = mem_q; end
      S_POPI: begin
        rf_we  = 1'b1;
        rf_wa  = RW'(SP_IDX);
        rf_wd  = sp_v + DW'(1);
        retire = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_F0;
      pc_q      <= '0;
      kind_q    <= K_HALT;
      len_q     <= '0;
      opa_q     <= '0;
      opb_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      halted    <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (go) begin
        case (st)
          S_F0: st <= S_F1;
          S_F1: begin
            kind_q <= kind_d;
            len_q  <= len_d;
            st     <= (len_d == 2'd0) ? S_EXEC : S_OPA;
          end
          S_OPA: begin
            opa_q <= mem_q[RW-1:0];
            st    <= (len_q == 2'd2) ? S_OPB : S_EXEC;
          end
          S_OPB: begin
            opb_q <= mem_q;
            st    <= S_EXEC;
          end
          S_EXEC: begin
            case (kind_q)
              K_HALT: begin halted <= 1'b1; st <= S_STOP; end
              K_BAD: begin
                halted  <= 1'b1;
                illegal <= 1'b1;
                st      <= S_STOP;
              end
              K_PRN: begin out_valid <= 1'b1; out_data <= rd_a; end
              K_PUSH:  st <= S_PUSHW;
              K_POP:   st <= S_POPW;
              default: ;
            endcase
          end
          S_POPW:  st <= S_POPI;
          default: ;
        endcase
        if (retire) begin
          pc_q <= pc_q + AW'(len_q) + AW'(1);
          st   <= S_F0;
        end
      end
    end
  end

endmodule

// File: rtl/cpu8_chk.sv
module cpu8_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          load_en,
  input logic          out_valid,
  input logic          halted,
  input logic          illegal,
  input logic [AW-1:0] pc
);

  // R3
  out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R9
  halt_pc_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc));

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !out_valid);

  // R10
  illegal_halts_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> halted);

  // R10
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |=> illegal);

  // R11
  stall_pc_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> $stable(pc));

endmodule

bind cpu8_core cpu8_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .load_en   (load_en),
  .out_valid (out_valid),
  .halted    (halted),
  .illegal   (illegal),
  .pc        (pc_q)
);

// File: tb/sim_cpu8_core.sv
module sim_cpu8_core;

  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_en = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [DW-1:0] load_data = '0;
  logic          out_valid, halted, illegal;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] img [256];
  logic [7:0] outs [32];
  int nout;
  int wp;

  always #2 clk = ~clk;

  cpu8_core #(.AW(AW), .DW(DW), .NREG(8)) u0 (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .out_valid(out_valid), .out_data(out_data),
    .halted(halted), .illegal(illegal)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic blank();
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
    wp = 0;
  endtask

  task automatic emit(input logic [7:0] b);
    img[wp] = b;
    wp++;
  endtask

  // Hold reset, write the whole image, leave reset asserted.
  task automatic load_image();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      load_en   = 1'b1;
      load_addr = AW'(i);
      load_data = img[i];
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic run(input int maxc);
    nout = 0;
    for (int c = 0; c < maxc; c++) begin
      @(negedge clk);
      if (out_valid && nout < 32) begin
        outs[nout] = out_data;
        nout++;
      end
      if (halted) break;
    end
  endtask

  task automatic t_reset();
    blank();
    emit(8'h47); emit(8'h00);
    emit(8'h47); emit(8'h07);
    emit(8'h47); emit(8'h03);
    emit(8'h01);
    load_image();
    chk("R1 halted in reset", int'(halted), 0);
    chk("R1 illegal in reset", int'(illegal), 0);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    run(200);
    chk("R1 emit count", nout, 3);
    chk("R1 reg0 reset", int'(outs[0]), 8'h00);
    chk("R1 reg7 reset", int'(outs[1]), 8'hF4);
    chk("R1 reg3 reset", int'(outs[2]), 8'h00);
  endtask

  task automatic t_ldi_prn();
    blank();
    emit(8'h82); emit(8'h00); emit(8'h08);
    emit(8'h47); emit(8'h00);
    emit(8'h82); emit(8'h05); emit(8'hA5);
    emit(8'h47); emit(8'h05);
    emit(8'h01);
    load_image();
    rst = 1'b0;
    run(200);
    chk("R8 emit count", nout, 2);
    chk("R2 ldi r0", int'(outs[0]), 8'h08);
    chk("R3 prn r5 order", int'(outs[1]), 8'hA5);
    chk("R9 halted after stop", int'(halted), 1);
  endtask

  task automatic t_mul();
    blank();
    emit(8'h82); emit(8'h01); emit(8'd20);
    emit(8'h82); emit(8'h02); emit(8'd13);
    emit(8'hA2); emit(8'h01); emit(8'h02);
    emit(8'h47); emit(8'h01);
    emit(8'h82); emit(8'h03); emit(8'd7);
    emit(8'h82); emit(8'h04); emit(8'd6);
    emit(8'hA2); emit(8'h03); emit(8'h04);
    emit(8'h47); emit(8'h03);
    emit(8'h01);
    load_image();
    rst = 1'b0;
    run(300);
    chk("R4 mul count", nout, 2);
    chk("R4 mul truncated", int'(outs[0]), 8'h04);
    chk("R4 mul small", int'(outs[1]), 8'd42);
  endtask

  task automatic t_stack();
    blank();
    emit(8'h82); emit(8'h00); emit(8'h11);
    emit(8'h82); emit(8'h01); emit(8'h22);
    emit(8'h45); emit(8'h00);
    emit(8'h45); emit(8'h01);
    emit(8'h47); emit(8'h07);
    emit(8'h46); emit(8'h02);
    emit(8'h46); emit(8'h03);
    emit(8'h47); emit(8'h02);
    emit(8'h47); emit(8'h03);
    emit(8'h47); emit(8'h07);
    emit(8'h46); emit(8'h04);
    emit(8'h47); emit(8'h04);
    emit(8'h47); emit(8'h07);
    emit(8'h01);
    img[8'hF4] = 8'h5C;
    load_image();
    rst = 1'b0;
    run(400);
    chk("R5 stack count", nout, 6);
    chk("R5 sp after two pushes", int'(outs[0]), 8'hF2);
    chk("R6 pop last pushed", int'(outs[1]), 8'h22);
    chk("R6 pop first pushed", int'(outs[2]), 8'h11);
    chk("R6 sp restored", int'(outs[3]), 8'hF4);
    chk("R6 pop preloaded cell", int'(outs[4]), 8'h5C);
    chk("R6 sp after pop", int'(outs[5]), 8'hF5);
  endtask

  task automatic t_wrap();
    blank();
    emit(8'h82); emit(8'h07); emit(8'h00);
    emit(8'h82); emit(8'h01); emit(8'h3C);
    emit(8'h45); emit(8'h01);
    emit(8'h47); emit(8'h07);
    emit(8'h46); emit(8'h02);
    emit(8'h47); emit(8'h02);
    emit(8'h47); emit(8'h07);
    emit(8'h01);
    load_image();
    rst = 1'b0;
    run(300);
    chk("R7 wrap count", nout, 3);
    chk("R7 push wraps to ff", int'(outs[0]), 8'hFF);
    chk("R7 value via ff", int'(outs[1]), 8'h3C);
    chk("R7 pop wraps to 00", int'(outs[2]), 8'h00);
  endtask

  task automatic t_halt();
    int late = 0;
    blank();
    emit(8'h01);
    emit(8'h47); emit(8'h07);
    load_image();
    rst = 1'b0;
    run(50);
    chk("R9 halted", int'(halted), 1);
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (out_valid || !halted) late++;
    end
    chk("R9 quiet and sticky", late, 0);
    chk("R9 no emits", nout, 0);
    chk("R9 not illegal", int'(illegal), 0);
  endtask

  task automatic t_illegal();
    int drop = 0;
    blank();
    emit(8'h82); emit(8'h00); emit(8'h01);
    emit(8'h47); emit(8'h00);
    emit(8'h03);
    emit(8'h47); emit(8'h00);
    load_image();
    rst = 1'b0;
    run(200);
    chk("R10 emits before bad op", nout, 1);
    chk("R10 halted", int'(halted), 1);
    chk("R10 illegal", int'(illegal), 1);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (!illegal || !halted || out_valid) drop++;
    end
    chk("R10 sticky", drop, 0);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 reset clears illegal", int'(illegal), 0);
    chk("R10 reset clears halted", int'(halted), 0);
  endtask

  task automatic t_stall();
    int early = 0;
    blank();
    emit(8'h82); emit(8'h02); emit(8'h10);
    emit(8'h47); emit(8'h02);
    emit(8'h01);
    load_image();
    @(negedge clk);
    rst       = 1'b0;
    load_en   = 1'b1;
    load_addr = 8'h02;
    load_data = 8'h77;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (out_valid || halted) early++;
    end
    chk("R11 core stalled", early, 0);
    load_en = 1'b0;
    run(200);
    chk("R11 emit count", nout, 1);
    chk("R11 rewritten operand", int'(outs[0]), 8'h77);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_ldi_prn();
    t_mul();
    t_stack();
    t_wrap();
    t_halt();
    t_illegal();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule